// File: doc/BRIEF.md
# Serial Line Deframer with Bit Destuffing and Frame Check

This block sits behind a clock-recovery stage. It receives one line sample per recovered bit tick and turns it into frame-level results. The line is transition coded. A sample equal to the previous one decodes to 1, and a changed sample decodes to 0. The reference level after reset is high. The decoded stream carries frames bounded by flag patterns. Inside a frame, the sender inserts a complementary bit after every five equal bits, whether ones or zeros. The block strips those inserted bits, finds the flags, and rejects runs that the sender could never have produced.

Each frame ends with a 16-bit check word. The block holds the destuffed stream in a short internal delay line, so the check word and the flag's leading bits never appear as payload. At the closing flag it reports whether the frame's check sum is correct. Payload bits come out serially with a valid strobe. The first bit of each frame carries a start pulse, and the closing flag gives an end pulse qualified by a good indication.

Top module: `nrzi_deframer`

## Requirements
- R1: A line sample equal to the previous sampled level decodes as 1, a changed level decodes as 0, and the reference level after reset is 1. Samples are taken only on cycles where `bit_tick` is high.
- R2: After five equal decoded bits, a following bit of the other value is dropped and is not part of the frame. Run counting then restarts with the next bit.
- R3: The decoded pattern 0,1,1,1,1,1,1,0 is a flag. None of its eight bits ever appears on `rx_bit`, including flag-like bytes inside stuffed payload.
- R4: Payload bits leave on `rx_bit` with `rx_valid` in arrival order, and each byte is sent most significant bit first. The 16 bits just before a closing flag are the check word and are never presented as payload.
- R5: `frame_start` pulses together with the first `rx_valid` of each frame, and at no other time.
- R6: At a closing flag that follows at least 16 frame bits, `frame_end` pulses with `frame_good` high when the check is correct. The check is a serial CRC with polynomial 0x1021 and start value 0xFFFF, run over payload and check word (check word sent most significant bit first, not inverted), and it is correct when the remainder is zero.
- R7: A frame whose check word does not match gives `frame_end` with `frame_good` low.
- R8: A closing flag after 1 to 15 frame bits gives `frame_end` with `frame_good` low and no payload.
- R9: Six equal zeros inside a frame give one `abort_err` pulse. The frame is dropped, so the next flag gives no `frame_end`.
- R10: Seven ones in a row inside a frame give one `abort_err` pulse and drop the frame in the same way.
- R11: Bits before the first flag after reset or after an abort are ignored, and two adjacent flags produce no frame event.
- R12: During reset and before any tick, every output is low.
- R13: Outputs change only in the cycle after a tick. Every strobe and pulse is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | High for one cycle per recovered bit |
| line_in | input | 1 | Sampled line level |
| rx_bit | output | 1 | Destuffed payload bit |
| rx_valid | output | 1 | `rx_bit` holds a payload bit this cycle |
| frame_start | output | 1 | First payload bit of a frame |
| frame_end | output | 1 | Closing flag of a frame seen |
| frame_good | output | 1 | Check correct, qualified by `frame_end` |
| abort_err | output | 1 | Illegal run inside a frame |

## Verification
A corrupted run counter shows up quickly. Within a byte, the bench either loses a stuffed bit or keeps an extra one, which misaligns every later payload bit against the scoreboard. It can also make a flag go unseen, which shows as a missing end event or a stray abort. An error in the delay-line fill count or the check register is invisible until the closing flag. There it shows as a wrong good indication, as check-word bits leaking onto `rx_bit`, or as leftover expected bits when the run ends. Abort handling is checked by counting pulses after each injected illegal run and by confirming that the next flag produces no end event.

// File: rtl/nrzi_deframer_pkg.sv
package nrzi_deframer_pkg;

  // Meaning of one decoded line bit after run analysis
  typedef enum logic [1:0] {
    CLS_DATA  = 2'd0,
    CLS_STUFF = 2'd1,
    CLS_FLAG  = 2'd2,
    CLS_ABORT = 2'd3
  } bit_class_e;

endpackage

// File: rtl/nrzi_line_decoder.sv
module nrzi_line_decoder #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  output logic dec_bit
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = prev_q;
    if (tick) begin
      prev_d = line_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE_LEVEL;
    end else begin
      prev_q <= prev_d;
    end
  end

  // unchanged level is a one, a change is a zero
  assign dec_bit = (line_in == prev_q);

endmodule

// File: rtl/nrzi_run_tracker.sv
module nrzi_run_tracker
  import nrzi_deframer_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bit_in,
  output bit_class_e cls
);

  localparam int FLAG_RUN = STUFF_RUN + 1;
  localparam int SAT_RUN  = STUFF_RUN + 2;
  localparam int LEN_W    = $clog2(SAT_RUN + 1);

  logic             run_val_q, run_val_d;
  logic [LEN_W-1:0] run_len_q, run_len_d;

  // classify the incoming bit against the run seen so far
  always_comb begin
    cls = CLS_DATA;
    if (run_len_q == LEN_W'(STUFF_RUN) && bit_in != run_val_q) begin
      cls = CLS_STUFF;
    end else if (run_len_q == LEN_W'(FLAG_RUN) && run_val_q && !bit_in) begin
      cls = CLS_FLAG;
    end else if (run_val_q == bit_in &&
                 (( bit_in && run_len_q == LEN_W'(FLAG_RUN)) ||
                  (!bit_in && run_len_q == LEN_W'(STUFF_RUN)))) begin
      cls = CLS_ABORT;
    end
  end

  always_comb begin
    run_val_d = run_val_q;
    run_len_d = run_len_q;
    if (tick) begin
      if (cls == CLS_STUFF || cls == CLS_FLAG) begin
        run_len_d = '0;
      end else if (run_len_q != '0 && bit_in == run_val_q) begin
        run_len_d = (run_len_q == LEN_W'(SAT_RUN)) ? run_len_q : run_len_q + 1'b1;
      end else begin
        run_val_d = bit_in;
        run_len_d = LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_val_q <= 1'b0;
      run_len_q <= '0;
    end else begin
      run_val_q <= run_val_d;
      run_len_q <= run_len_d;
    end
  end

endmodule

// File: rtl/nrzi_crc_serial.sv
module nrzi_crc_serial #(
  parameter int             CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] crc_d;
  logic             fb;

  always_comb begin
    fb    = crc[CRC_W-1] ^ bit_in;
    crc_d = crc;
    if (clr) begin
      crc_d = CRC_INIT;
    end else if (en) begin
      crc_d = {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= CRC_INIT;
    end else begin
      crc <= crc_d;
    end
  end

endmodule

// File: rtl/nrzi_deframer.sv
module nrzi_deframer
  import nrzi_deframer_pkg::*;
#(
  parameter int               STUFF_RUN = 5,
  parameter int               CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD  = 16'h0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic line_in,
  output logic rx_bit,
  output logic rx_valid,
  output logic frame_start,
  output logic frame_end,
  output logic frame_good,
  output logic abort_err
);

  // bits of a closing flag already accepted when it is recognised
  localparam int FLAG_TAIL = STUFF_RUN + 2;
  localparam int DLY       = CRC_W + FLAG_TAIL;
  localparam int FILL_W    = $clog2(DLY + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic       dec_bit;
  bit_class_e cls;

  nrzi_line_decoder #(.IDLE_LEVEL(1'b1)) u_dec (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (bit_tick),
    .line_in (line_in),
    .dec_bit (dec_bit)
  );

  nrzi_run_tracker #(.STUFF_RUN(STUFF_RUN)) u_run (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick   (bit_tick),
    .bit_in (dec_bit),
    .cls    (cls)
  );

  logic [DLY-1:0]    sr_q, sr_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              in_frame_q, in_frame_d;
  logic              first_q, first_d;
  logic              bit_d, valid_d, start_d, end_d, good_d, abort_d;
  logic              crc_clr, crc_en, crc_bit;
  logic [CRC_W-1:0]  crc;

  nrzi_crc_serial #(
    .CRC_W    (CRC_W),
    .CRC_POLY (CRC_POLY),
    .CRC_INIT (CRC_INIT)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr    (crc_clr),
    .en     (crc_en),
    .bit_in (crc_bit),
    .crc    (crc)
  );

  logic push, flag_hit, run_bad;
  assign push     = bit_tick && (cls == CLS_DATA);
  assign flag_hit = bit_tick && (cls == CLS_FLAG);
  assign run_bad  = bit_tick && (cls == CLS_ABORT);
  assign crc_bit  = sr_q[FLAG_TAIL-1];

  always_comb begin
    sr_d       = sr_q;
    fill_d     = fill_q;
    in_frame_d = in_frame_q;
    first_d    = first_q;
    bit_d      = rx_bit;
    valid_d    = 1'b0;
    start_d    = 1'b0;
    end_d      = 1'b0;
    good_d     = 1'b0;
    abort_d    = 1'b0;
    crc_clr    = 1'b0;
    crc_en     = 1'b0;
    if (flag_hit) begin
      end_d      = in_frame_q && (fill_q > FILL_W'(FLAG_TAIL));
      good_d     = in_frame_q && (fill_q == FILL_W'(DLY)) && (crc == CRC_GOOD);
      in_frame_d = 1'b1;
      first_d    = 1'b1;
      fill_d     = '0;
      crc_clr    = 1'b1;
    end else if (run_bad) begin
      abort_d    = in_frame_q;
      in_frame_d = 1'b0;
      fill_d     = '0;
      crc_clr    = 1'b1;
    end else if (push) begin
      sr_d    = {sr_q[DLY-2:0], dec_bit};
      fill_d  = (fill_q == FILL_W'(DLY)) ? fill_q : fill_q + 1'b1;
      crc_en  = (fill_q >= FILL_W'(FLAG_TAIL));
      valid_d = in_frame_q && (fill_q == FILL_W'(DLY));
      bit_d   = sr_q[DLY-1];
      start_d = valid_d && first_q;
      first_d = first_q && !valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sr_q        <= '0;
      fill_q      <= '0;
      in_frame_q  <= 1'b0;
      first_q     <= 1'b0;
      rx_bit      <= 1'b0;
      rx_valid    <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      frame_good  <= 1'b0;
      abort_err   <= 1'b0;
    end else begin
      sr_q        <= sr_d;
      fill_q      <= fill_d;
      in_frame_q  <= in_frame_d;
      first_q     <= first_d;
      rx_bit      <= bit_d;
      rx_valid    <= valid_d;
      frame_start <= start_d;
      frame_end   <= end_d;
      frame_good  <= good_d;
      abort_err   <= abort_d;
    end
  end

endmodule

// File: rtl/nrzi_deframer_chk.sv
module nrzi_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic rx_valid,
  input logic frame_start,
  input logic frame_end,
  input logic frame_good,
  input logic abort_err
);

  // R5
  start_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> rx_valid);

  // R6
  good_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> frame_end);

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_err |-> (!rx_valid && !frame_end));

  // R3
  flag_no_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !rx_valid);

  // R13
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> (!rx_valid && !frame_end && !abort_err && !frame_start));

  // R12
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!rx_valid && !frame_start && !frame_end && !frame_good && !abort_err);
    end
  end

endmodule

bind nrzi_deframer nrzi_deframer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_tick    (bit_tick),
  .rx_valid    (rx_valid),
  .frame_start (frame_start),
  .frame_end   (frame_end),
  .frame_good  (frame_good),
  .abort_err   (abort_err)
);

// File: tb/sim_nrzi_deframer.sv
module sim_nrzi_deframer;

  logic clk;
  logic rst_n;
  logic bit_tick;
  logic line_in;
  logic rx_bit, rx_valid, frame_start, frame_end, frame_good, abort_err;

  int checks;
  int errors;
  int abort_exp;
  int abort_seen;
  bit done;

  logic [1:0] bit_q[$];   // {first, bit}
  logic       end_q[$];   // expected good flag

  logic tx_level;
  logic tx_run_val;
  int   tx_run_len;

  nrzi_deframer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .line_in     (line_in),
    .rx_bit      (rx_bit),
    .rx_valid    (rx_valid),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_good  (frame_good),
    .abort_err   (abort_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic report(input bit ok, input string req, input string what,
                        input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R1: transition coding, a zero toggles the line
  task automatic drive_level(input logic lv);
    @(negedge clk);
    line_in  = lv;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic send_raw(input logic b);
    if (!b) tx_level = ~tx_level;
    drive_level(tx_level);
  endtask

  // R2: sender inserts the complement after five equal bits
  task automatic send_stuffed(input logic b);
    send_raw(b);
    if (tx_run_len != 0 && b == tx_run_val) tx_run_len++;
    else begin
      tx_run_val = b;
      tx_run_len = 1;
    end
    if (tx_run_len == 5) begin
      send_raw(~b);
      tx_run_len = 0;
    end
  endtask

  task automatic send_flag();
    send_stuffed(1'b0);
    repeat (6) send_raw(1'b1);
    send_raw(1'b0);
    tx_run_len = 0;
  endtask

  task automatic send_frame(input logic [63:0] payload, input int nbytes, input bit corrupt);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 8 * nbytes - 1; i >= 0; i--) begin
      bit_q.push_back({(i == 8 * nbytes - 1), payload[i]});
      c = crc_step(c, payload[i]);
    end
    if (corrupt) c[0] = ~c[0];
    end_q.push_back(!corrupt);
    for (int i = 8 * nbytes - 1; i >= 0; i--) send_stuffed(payload[i]);
    for (int i = 15; i >= 0; i--) send_stuffed(c[i]);
    send_flag();
  endtask

  // monitor: compare outputs with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid) begin
        if (bit_q.size() == 0) begin
          report(1'b0, "R4", "unexpected payload bit", 1, 0);
        end else begin
          logic [1:0] e;
          e = bit_q.pop_front();
          report(rx_bit == e[0], "R4", "payload bit", int'(rx_bit), int'(e[0]));
          report(frame_start == e[1], "R5", "frame_start", int'(frame_start), int'(e[1]));
        end
      end else if (frame_start) begin
        report(1'b0, "R5", "frame_start without bit", 1, 0);
      end
      if (frame_end) begin
        if (end_q.size() == 0) begin
          report(1'b0, "R11", "unexpected frame_end", 1, 0);
        end else begin
          logic g;
          g = end_q.pop_front();
          report(frame_good == g, "R6 R7 R8", "frame_good", int'(frame_good), int'(g));
        end
      end
      if (abort_err) abort_seen++;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      report(1'b0, "WATCHDOG", "run did not end", 0, 1);
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; abort_exp = 0; abort_seen = 0; done = 1'b0;
    rst_n = 1'b0; bit_tick = 1'b0; line_in = 1'b1;
    tx_level = 1'b1; tx_run_val = 1'b0; tx_run_len = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    report({rx_valid, frame_start, frame_end, frame_good, abort_err} == 5'b0,
           "R12", "outputs in reset", int'({rx_valid, frame_start, frame_end, frame_good, abort_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report({rx_valid, frame_start, frame_end, frame_good, abort_err} == 5'b0,
           "R12", "outputs after reset", int'({rx_valid, frame_start, frame_end, frame_good, abort_err}), 0);

    // R11: idle and garbage before the first flag
    repeat (10) send_raw(1'b1);
    for (int i = 7; i >= 0; i--) send_raw(8'h5A >> i);
    tx_run_len = 0;
    send_flag();

    send_frame(64'hA5, 1, 1'b0);              // R6
    send_frame(64'hFFFF, 2, 1'b0);            // R2 ones
    send_frame(64'h000000, 3, 1'b0);          // R2 zeros
    send_frame(64'h7E7E, 2, 1'b0);            // R3 flag-like bytes
    send_frame(64'h123456789A, 5, 1'b1);      // R7 bad check word

    // R8: too short
    end_q.push_back(1'b0);
    for (int i = 7; i >= 0; i--) send_stuffed(8'h3C >> i);
    send_flag();

    // R11: adjacent flag
    send_flag();

    // R9: six zeros
    for (int i = 7; i >= 0; i--) send_stuffed(8'h55 >> i);
    repeat (6) send_raw(1'b0);
    tx_run_len = 0;
    abort_exp++;
    send_flag();
    repeat (4) @(negedge clk);
    report(abort_seen == abort_exp, "R9", "abort count", abort_seen, abort_exp);

    // R10: seven ones
    for (int i = 7; i >= 0; i--) send_stuffed(8'hAA >> i);
    repeat (7) send_raw(1'b1);
    tx_run_len = 0;
    abort_exp++;
    send_flag();
    repeat (4) @(negedge clk);
    report(abort_seen == abort_exp, "R10", "abort count", abort_seen, abort_exp);

    send_frame(64'hC3E1, 2, 1'b0);            // recovery
    send_frame(64'h0F81F0, 3, 1'b0);          // mixed runs

    repeat (20) @(negedge clk);
    report(bit_q.size() == 0, "R4", "payload bits left", bit_q.size(), 0);
    report(end_q.size() == 0, "R11", "frame ends left", end_q.size(), 0);
    report(abort_seen == abort_exp, "R13", "total aborts", abort_seen, abort_exp);
    done = 1'b1;
    finish_run();
  end

endmodule